// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from an external source that owns the clocks. The source supplies three signals: a bit clock, a frame clock that marks the channel or frame boundaries, and a serial data line. The block brings the three signals into the system clock domain through two-flop synchronisers and detects the sampling edge of the bit clock there. It then deserialises each channel word into a parallel sample. When both the left and the right word of a frame have been taken, it presents them together with a one-cycle valid strobe.

Four framing styles are handled. Right-justified places the LSB at the end of the channel slot. Left-justified places the MSB at the start of the slot. I2S delays the MSB by one bit. The pulse-framed DSP style has two variants. The word length can be 16, 20, 24 or 32 bits. Static configuration inputs select the sampling edge of the bit clock, the sense of the frame clock (or the DSP variant), a left/right exchange and a mono mode. Samples are delivered left-aligned in a 32-bit word, with the unused low bits zero.

Top module: `sai_rx_top`

## Requirements
- R1: While reset is held and directly after it is released, `smp_valid_o` is low and both sample outputs are zero.
- R2: Serial data and frame clock are sampled on the rising bit-clock edge. With `cfg_sck_inv_i`=1 the falling edge of the pin is the sampling edge instead.
- R3: Format code 01 (left-justified): the MSB is taken on the first sampling edge after a frame-clock change. Frame clock high marks the left channel.
- R4: Format code 10 (I2S): the MSB is taken on the second sampling edge after a frame-clock change. Frame clock low marks the left channel.
- R5: Format code 00 (right-justified): the LSB is taken on the last sampling edge before a frame-clock change. Bits earlier in the slot than the word are dropped. Frame clock high marks the left channel.
- R6: In right-justified format, word-length code 11 gives a 24-bit word: only the last 24 bits of the slot are kept.
- R7: Format code 11 (DSP): a frame starts on a rising frame clock. The left word is followed at once by the right word. In variant A the left MSB is taken on the second sampling edge of the frame; in variant B it is taken on the first.
- R8: Word-length codes 00/01/10/11 select 16/20/24/32 bits.
- R9: `cfg_ws_inv_i`=1 inverts the frame-clock sense in the three non-DSP formats. In DSP format it selects variant B instead of A, and it does not invert the frame clock.
- R10: Each sample is left-aligned in the 32-bit output with its low bits zero. Slot bits after the word (or after the right word in DSP format) are ignored.
- R11: `smp_valid_o` pulses for exactly one system cycle per frame, after the right word has been captured, and only if a left word was captured before it. Every transmitted frame yields exactly one strobe.
- R12: `cfg_swap_i`=1 outputs the left-slot sample on `smp_right_o` and the right-slot sample on `smp_left_o`.
- R13: `cfg_mono_i`=1 drives both outputs with the left-slot sample, whatever `cfg_swap_i` is.
- R14: All three serial inputs pass through matched two-flop synchronisers. Correct operation needs a system clock of at least four times the bit clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock from the source |
| ws_i | input | 1 | Frame / word-select clock |
| sd_i | input | 1 | Serial data, MSB first |
| cfg_fmt_i | input | 2 | Framing: 00 right-justified, 01 left-justified, 10 I2S, 11 DSP |
| cfg_wlen_i | input | 2 | Word length: 00 16, 01 20, 10 24, 11 32 bits |
| cfg_sck_inv_i | input | 1 | Sample on the falling pin edge |
| cfg_ws_inv_i | input | 1 | Frame-clock inversion, or DSP variant B |
| cfg_swap_i | input | 1 | Exchange left and right outputs |
| cfg_mono_i | input | 1 | Both outputs carry the left-slot sample |
| smp_valid_o | output | 1 | One-cycle strobe: a new frame is on the outputs |
| smp_left_o | output | 32 | Left sample, left-aligned |
| smp_right_o | output | 32 | Right sample, left-aligned |

## Verification
The assertions assume that sampling edges arrive at least four system cycles apart. They also assume that the configuration inputs stay fixed while a stream runs. The bench meets the first assumption by holding each bit-clock phase for four system cycles. It meets the second by changing configuration only under reset. The frame clock and data change together with the non-sampling bit-clock edge, as a real source would drive them. Every slot is 34 bits wide, so a 32-bit I2S word still fits after its one-bit delay. The bits outside each word are driven to ones, so that any leak into the samples shows up as a mismatch.

// File: rtl/sai_rx_pkg.sv
package sai_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ  = 2'b00,
    FMT_LJ  = 2'b01,
    FMT_I2S = 2'b10,
    FMT_DSP = 2'b11
  } fmt_e;

  typedef enum logic [1:0] {
    WL_16 = 2'b00,
    WL_20 = 2'b01,
    WL_24 = 2'b10,
    WL_32 = 2'b11
  } wlen_e;

  // Effective word length; right-justified framing tops out at 24 bits.
  function automatic logic [5:0] wl_bits(wlen_e w, fmt_e f);
    logic [5:0] n;
    case (w)
      WL_16:   n = 6'd16;
      WL_20:   n = 6'd20;
      WL_24:   n = 6'd24;
      default: n = (f == FMT_RJ) ? 6'd24 : 6'd32;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/sai_rx_sync.sv
module sai_rx_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] in_i,
  output logic [WIDTH-1:0] out_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= in_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign out_o = stg_q[STAGES-1];

endmodule

// File: rtl/sai_rx_bitedge.sv
module sai_rx_bitedge (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_s,
  input  logic sck_inv,
  output logic edge_o
);

  logic sck_eff;
  logic prev_q;

  assign sck_eff = sck_s ^ sck_inv;
  assign edge_o  = sck_eff & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sck_eff;
  end

  // R14: with a system clock at least 4x the bit clock, edges stay spaced
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |=> !edge_o ##1 !edge_o ##1 !edge_o);

endmodule

// File: rtl/sai_rx_slot.sv
module sai_rx_slot
  import sai_rx_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  bit_edge,
  input  logic  ws_s,
  input  fmt_e  fmt,
  input  wlen_e wlen,
  input  logic  ws_inv,
  output logic  cap_v,
  output logic  cap_right,
  output logic  cap_tail
);

  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  logic             primed_q, primed_d;
  logic             ws_prev_q, ws_prev_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] idx_cur, pos, off_v, last1, last2;
  logic [5:0]       nbits;
  logic             ws_eff, trans, off, in_rng;

  // frame decode and capture selection
  always_comb begin
    nbits   = wl_bits(wlen, fmt);
    ws_eff  = (fmt == FMT_DSP) ? ws_s : (ws_s ^ ws_inv);
    off     = (fmt == FMT_I2S) || ((fmt == FMT_DSP) && !ws_inv);
    off_v   = {{(IDX_W-1){1'b0}}, off};
    if (fmt == FMT_DSP) trans = primed_q & ws_eff & ~ws_prev_q;
    else                trans = primed_q & (ws_eff ^ ws_prev_q);
    idx_cur = trans ? '0 : idx_q;
    in_rng  = (idx_cur >= off_v);
    pos     = idx_cur - off_v;
    last1   = IDX_W'(nbits) - IDX_ONE;
    last2   = IDX_W'({nbits, 1'b0}) - IDX_ONE;

    cap_v     = 1'b0;
    cap_right = 1'b0;
    cap_tail  = 1'b0;
    case (fmt)
      FMT_RJ: begin
        cap_v     = trans;
        cap_right = ~ws_prev_q;
        cap_tail  = 1'b1;
      end
      FMT_LJ: begin
        cap_v     = in_rng && (pos == last1);
        cap_right = ~ws_eff;
      end
      FMT_I2S: begin
        cap_v     = in_rng && (pos == last1);
        cap_right = ws_eff;
      end
      default: begin
        if (in_rng && (pos == last1)) begin
          cap_v = 1'b1;
        end else if (in_rng && (pos == last2)) begin
          cap_v     = 1'b1;
          cap_right = 1'b1;
        end
      end
    endcase
    cap_v = cap_v & bit_edge;
  end

  // next state
  always_comb begin
    primed_d  = primed_q;
    ws_prev_d = ws_prev_q;
    idx_d     = idx_q;
    if (bit_edge) begin
      primed_d  = 1'b1;
      ws_prev_d = ws_eff;
      if (trans)                idx_d = IDX_ONE;
      else if (idx_q != IDX_MAX) idx_d = idx_q + IDX_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q  <= 1'b0;
      ws_prev_q <= 1'b0;
      idx_q     <= IDX_MAX;
    end else begin
      primed_q  <= primed_d;
      ws_prev_q <= ws_prev_d;
      idx_q     <= idx_d;
    end
  end

  // R7: in DSP framing the right word never closes before the left one
  dsp_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_v && cap_right && fmt == FMT_DSP) |-> (idx_q > last1));

endmodule

// File: rtl/sai_rx_top.sv
module sai_rx_top
  import sai_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_i,
  input  logic                ws_i,
  input  logic                sd_i,
  input  logic [1:0]          cfg_fmt_i,
  input  logic [1:0]          cfg_wlen_i,
  input  logic                cfg_sck_inv_i,
  input  logic                cfg_ws_inv_i,
  input  logic                cfg_swap_i,
  input  logic                cfg_mono_i,
  output logic                smp_valid_o,
  output logic [SAMPLE_W-1:0] smp_left_o,
  output logic [SAMPLE_W-1:0] smp_right_o
);

  // SAMPLE_W must be at least the longest word (32)
  localparam int IDX_W = $clog2(2 * SAMPLE_W + 4);
  localparam int SHW   = $clog2(SAMPLE_W + 1);

  fmt_e  fmt;
  wlen_e wlen;
  assign fmt  = fmt_e'(cfg_fmt_i);
  assign wlen = wlen_e'(cfg_wlen_i);

  logic sck_s, ws_s, sd_s, bit_edge;
  logic cap_v, cap_right, cap_tail;

  sai_rx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .in_i  ({sck_i, ws_i, sd_i}),
    .out_o ({sck_s, ws_s, sd_s})
  );

  sai_rx_bitedge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .sck_s   (sck_s),
    .sck_inv (cfg_sck_inv_i),
    .edge_o  (bit_edge)
  );

  sai_rx_slot #(.IDX_W(IDX_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_edge  (bit_edge),
    .ws_s      (ws_s),
    .fmt       (fmt),
    .wlen      (wlen),
    .ws_inv    (cfg_ws_inv_i),
    .cap_v     (cap_v),
    .cap_right (cap_right),
    .cap_tail  (cap_tail)
  );

  logic [SAMPLE_W-1:0] hist_q, hist_d, word, aligned;
  logic [SAMPLE_W-1:0] hold_q, hold_d, out_l_d, out_r_d;
  logic                have_q, have_d, valid_d;
  logic [5:0]          nbits;
  logic [SHW-1:0]      shamt;

  always_comb begin
    nbits   = wl_bits(wlen, fmt);
    shamt   = SHW'(SAMPLE_W) - SHW'(nbits);
    hist_d  = bit_edge ? {hist_q[SAMPLE_W-2:0], sd_s} : hist_q;
    word    = cap_tail ? hist_q : hist_d;
    aligned = word << shamt;

    hold_d  = hold_q;
    have_d  = have_q;
    valid_d = 1'b0;
    if (cap_v && !cap_right) begin
      hold_d = aligned;
      have_d = 1'b1;
    end else if (cap_v && cap_right) begin
      valid_d = have_q;
      have_d  = 1'b0;
    end

    if (cfg_mono_i) begin
      out_l_d = hold_q;
      out_r_d = hold_q;
    end else if (cfg_swap_i) begin
      out_l_d = aligned;
      out_r_d = hold_q;
    end else begin
      out_l_d = hold_q;
      out_r_d = aligned;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q      <= '0;
      hold_q      <= '0;
      have_q      <= 1'b0;
      smp_valid_o <= 1'b0;
      smp_left_o  <= '0;
      smp_right_o <= '0;
    end else begin
      hist_q      <= hist_d;
      hold_q      <= hold_d;
      have_q      <= have_d;
      smp_valid_o <= valid_d;
      if (valid_d) begin
        smp_left_o  <= out_l_d;
        smp_right_o <= out_r_d;
      end
    end
  end

  // R11
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |=> !smp_valid_o);

  // R11
  pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid_o) |-> $past(cap_v && cap_right));

  // R10
  pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_o |-> ((smp_left_o << nbits) == '0 && (smp_right_o << nbits) == '0));

  // R13
  mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_o && cfg_mono_i) |-> (smp_left_o == smp_right_o));

endmodule

// File: tb/sai_rx_top_tb_top.sv
module sai_rx_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4;
  localparam int SLOT       = 34;
  localparam int WDOG       = 150000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sck, ws, sd;
  logic [1:0]  cfg_fmt, cfg_wlen;
  logic        cfg_sck_inv, cfg_ws_inv, cfg_swap, cfg_mono;
  logic        smp_valid;
  logic [31:0] smp_left, smp_right;

  int checks = 0;
  int errors = 0;

  logic [31:0] q_l[$];
  logic [31:0] q_r[$];
  string       q_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sai_rx_top dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_i         (sck),
    .ws_i          (ws),
    .sd_i          (sd),
    .cfg_fmt_i     (cfg_fmt),
    .cfg_wlen_i    (cfg_wlen),
    .cfg_sck_inv_i (cfg_sck_inv),
    .cfg_ws_inv_i  (cfg_ws_inv),
    .cfg_swap_i    (cfg_swap),
    .cfg_mono_i    (cfg_mono),
    .smp_valid_o   (smp_valid),
    .smp_left_o    (smp_left),
    .smp_right_o   (smp_right)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a frame is presented
  logic v_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (v_prev && smp_valid)
        check(1'b0, "R11", "strobe longer than one cycle", 32'd1, 32'd0);
      if (smp_valid) begin
        if (q_l.size() == 0) begin
          check(1'b0, "R11", "unexpected strobe", smp_left, 32'd0);
        end else begin
          logic [31:0] el, er;
          string t;
          el = q_l.pop_front();
          er = q_r.pop_front();
          t  = q_tag.pop_front();
          check(smp_left == el, t, "left sample", smp_left, el);
          check(smp_right == er, t, "right sample", smp_right, er);
        end
      end
    end
    v_prev = rst_n && smp_valid;
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog expired actual=hang expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic int wl_num(input logic [1:0] c);
    case (c)
      2'b00:   return 16;
      2'b01:   return 20;
      2'b10:   return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] align(input logic [31:0] s, input int n);
    logic [63:0] m;
    m = (64'h1 << n) - 64'h1;
    return (s & m[31:0]) << (32 - n);
  endfunction

  task automatic send_bit(input logic lv, input logic d);
    @(negedge clk);
    sck = cfg_sck_inv;
    ws  = lv;
    sd  = d;
    repeat (HALF_BIT) @(negedge clk);
    sck = ~cfg_sck_inv;
    repeat (HALF_BIT - 1) @(negedge clk);
  endtask

  // data bit at slot position j for the non-DSP formats; ones outside the word
  function automatic logic slot_bit(input logic [1:0] f, input int n,
                                    input logic [31:0] s, input int j);
    case (f)
      2'b01:   return (j < n) ? s[n-1-j] : 1'b1;
      2'b10:   return (j >= 1 && j <= n) ? s[n-j] : 1'b1;
      default: return (j >= SLOT - n) ? s[SLOT-1-j] : 1'b1;
    endcase
  endfunction

  task automatic run_case(input string tag, input logic [1:0] f, input logic [1:0] wl,
                          input logic bcp, input logic lrp, input logic swp,
                          input logic mno, input int nfr, input int seed);
    int n, ne;
    logic lv_l, lv_r;
    rst_n       = 1'b0;
    cfg_fmt     = f;
    cfg_wlen    = wl;
    cfg_sck_inv = bcp;
    cfg_ws_inv  = lrp;
    cfg_swap    = swp;
    cfg_mono    = mno;
    sck = bcp; ws = 1'b0; sd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n  = wl_num(wl);
    ne = (f == 2'b00 && n == 32) ? 24 : n;
    lv_l = ((f == 2'b10) ? 1'b0 : 1'b1) ^ lrp;
    lv_r = ~lv_l;
    if (f == 2'b11) begin
      for (int i = 0; i < 3; i++) send_bit(1'b0, 1'b0);
    end else begin
      for (int i = 0; i < 3; i++) send_bit(lv_r, 1'b0);
    end
    for (int fr = 0; fr < nfr; fr++) begin
      logic [31:0] sl, sr, el, er;
      sl = 32'h9E37_79B9 * (seed + fr + 1) ^ 32'h5A5A_0F0F;
      sr = 32'h7F4A_7C15 * (seed + 2 * fr + 3) ^ 32'hC3C3_1234;
      el = align(sl, ne);
      er = align(sr, ne);
      q_tag.push_back(tag);
      if (mno) begin
        q_l.push_back(el); q_r.push_back(el);
      end else if (swp) begin
        q_l.push_back(er); q_r.push_back(el);
      end else begin
        q_l.push_back(el); q_r.push_back(er);
      end
      if (f == 2'b11) begin
        int off;
        off = lrp ? 0 : 1;
        for (int j = 0; j < 2 * SLOT; j++) begin
          int p;
          logic d;
          p = j - off;
          if (p >= 0 && p < n)          d = sl[n-1-p];
          else if (p >= n && p < 2 * n) d = sr[2*n-1-p];
          else                          d = 1'b1;
          send_bit(j == 0, d);
        end
      end else begin
        for (int j = 0; j < SLOT; j++) send_bit(lv_l, slot_bit(f, n, sl, j));
        for (int j = 0; j < SLOT; j++) send_bit(lv_r, slot_bit(f, n, sr, j));
      end
    end
    // trailing bits close the last right-justified word
    for (int i = 0; i < 3; i++) send_bit((f == 2'b11) ? 1'b0 : lv_l, 1'b0);
    repeat (20) @(negedge clk);
    check(q_l.size() == 0, tag, "frames not delivered (R11)", q_l.size(), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0;
    sck = 1'b0; ws = 1'b0; sd = 1'b0;
    cfg_fmt = 2'b01; cfg_wlen = 2'b00;
    cfg_sck_inv = 1'b0; cfg_ws_inv = 1'b0; cfg_swap = 1'b0; cfg_mono = 1'b0;
    repeat (4) @(negedge clk);
    check(smp_valid == 1'b0, "R1", "valid in reset", smp_valid, 32'd0);
    check(smp_left == 32'd0, "R1", "left in reset", smp_left, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(smp_right == 32'd0, "R1", "right after reset", smp_right, 32'd0);
    check(smp_valid == 1'b0, "R1", "valid after reset", smp_valid, 32'd0);

    run_case("R3 R8 R10 left-justified 24b", 2'b01, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 3, 1);
    run_case("R4 R8 I2S 16b",                 2'b10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3, 7);
    run_case("R4 R9 I2S 32b inverted frame",  2'b10, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 3, 11);
    run_case("R5 R8 right-justified 20b",     2'b00, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 3, 13);
    run_case("R6 right-justified 32b as 24b", 2'b00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 3, 17);
    run_case("R7 DSP variant A 16b",          2'b11, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 3, 19);
    run_case("R7 R9 DSP variant B 24b",       2'b11, 2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 3, 23);
    run_case("R2 R14 left-justified 32b falling edge", 2'b01, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 3, 29);
    run_case("R12 swap left-justified 20b",   2'b01, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 2, 31);
    run_case("R13 mono I2S 24b swap set",     2'b10, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 2, 37);
    run_case("R2 R7 DSP variant A 20b falling edge", 2'b11, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 2, 41);
    run_case("R5 R9 R10 right-justified 16b inverted frame", 2'b00, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 2, 43);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule